// File: doc/BRIEF.md
# Two-Word Burst DDR SRAM Controller

This block sits between a simple request port and a synchronous double-data-rate SRAM that moves two words on every access. A user request carries a valid strobe, a write select, an address and two write words. The controller turns each accepted request into one command cycle on the memory side. That command cycle drives an active-low load strobe, an active-low read/write select (high means read) and the address.

Write data leaves one cycle after its command, as a rising-phase lane and a falling-phase lane, together with a drive enable. Read data comes back on the same two lanes after a latency that a parameter sets in half-cycles. The controller registers the returning pair and presents it with a one-cycle valid flag. The whole design runs in one clock domain; the two phases of the bus are modelled as two parallel lanes.

The memory pairs its two words on addresses that differ only in the lowest bit. The rising lane always carries the word at the address that was issued, and the falling lane carries the word at that address with bit 0 inverted. Requests may be issued back to back. The only stall is a one-cycle bubble that keeps a read from following a write directly.

Top module: `ddrb2_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, the load strobe and read/write select are high, the drive enable is low, and the response valid is low.
- R2: A request accepted at a clock edge (valid and ready both high) appears on the memory pins for exactly the next cycle: load strobe low, read/write select high for a read and low for a write, and the request address.
- R3: In a cycle with no accepted request the load strobe is high, and the drive enable is low unless R4 requires it.
- R4: The drive enable is high exactly in the cycle after a write command cycle. In that cycle the rising lane carries the first write word and the falling lane carries the second.
- R5: With RDC = ceil(RD_LAT_HALF / 2) cycles (default latency 3 half-cycles, so RDC = 2), the memory's read lanes are sampled RDC edges after the edge that samples the read command. The response valid is high for one cycle, starting RDC + 1 edges after the accepting edge.
- R6: One request per cycle is accepted back to back, except as R7 states. Every read produces exactly one response, and responses come in request order.
- R7: When a write was accepted at the previous edge and a read is now requested, ready is low for that one cycle. In every other case ready is high.
- R8: The first response word is the content of the issued address A, and the second is the content of A with bit 0 inverted. A write at A stores its first word at A and its second at A with bit 0 inverted, so even and odd start addresses give opposite word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Start address of the two-word burst |
| req_wdata0 | input | DW | First write word (to the issued address) |
| req_wdata1 | input | DW | Second write word (to the paired address) |
| req_ready | output | 1 | Request can be accepted this cycle |
| rsp_valid | output | 1 | Read pair valid, one cycle per read |
| rsp_rdata0 | output | DW | Word at the issued read address |
| rsp_rdata1 | output | DW | Word at the paired address |
| mem_ld_n | output | 1 | Active-low command strobe |
| mem_rw_n | output | 1 | High for read, low for write |
| mem_addr | output | AW | Command address |
| mem_wd_rise | output | DW | Write data, rising-phase lane |
| mem_wd_fall | output | DW | Write data, falling-phase lane |
| mem_wd_oe | output | 1 | Write data drive enable |
| mem_rd_rise | input | DW | Read data, rising-phase lane |
| mem_rd_fall | input | DW | Read data, falling-phase lane |

## Verification
Two functions can land in the same cycle. One is driving a write pair onto the lanes; the other is issuing a fresh command, which may be a read whose data will later use the same shared bus. The bench provokes this by offering a read in the cycle right after every accepted write, and also by issuing write-write and read-write pairs with no gap. For each cycle it predicts whether ready must fall, and it confirms that the command and the write drive enable appear in the cycles that R2 and R4 fix. A behavioural memory with the same latency and pairing order then has to return every pair intact and in order.

// File: rtl/ddrb2_pkg.sv
package ddrb2_pkg;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } op_e;

    // Whole cycles between the memory sampling a read command and the
    // edge at which both lanes of the returned pair can be captured.
    function automatic int rd_cycles(input int lat_half);
        int l;
        l = (lat_half < 1) ? 1 : lat_half;
        return (l + 1) / 2;
    endfunction

endpackage

// File: rtl/ddrb2_issue.sv
module ddrb2_issue #(
    parameter int AW = 19,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata0,
    input  logic [DW-1:0] req_wdata1,
    output logic          req_ready,
    output logic          mem_ld_n,
    output logic          mem_rw_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wd_rise,
    output logic [DW-1:0] mem_wd_fall,
    output logic          mem_wd_oe,
    output logic          rd_issue
);
    import ddrb2_pkg::*;

    typedef struct packed {
        logic          ld_n;
        logic          rw_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] hold0;
        logic [DW-1:0] hold1;
        logic [DW-1:0] rise;
        logic [DW-1:0] fall;
        logic          oe;
        logic          prev_wr;
    } issue_t;

    issue_t q, d;
    logic   accept;

    // A read offered right after an accepted write waits one cycle.
    assign req_ready = !(q.prev_wr && (op_e'(!req_write) == OP_READ));
    assign accept    = req_valid && req_ready;

    always_comb begin
        d         = q;
        d.ld_n    = !accept;
        d.rw_n    = !(accept && req_write);
        if (accept) begin
            d.addr = req_addr;
        end
        if (accept && req_write) begin
            d.hold0 = req_wdata0;
            d.hold1 = req_wdata1;
        end
        d.oe      = !q.ld_n && !q.rw_n;
        if (d.oe) begin
            d.rise = q.hold0;
            d.fall = q.hold1;
        end
        d.prev_wr = accept && req_write;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{ld_n: 1'b1, rw_n: 1'b1, default: '0};
        end else begin
            q <= d;
        end
    end

    assign mem_ld_n    = q.ld_n;
    assign mem_rw_n    = q.rw_n;
    assign mem_addr    = q.addr;
    assign mem_wd_rise = q.rise;
    assign mem_wd_fall = q.fall;
    assign mem_wd_oe   = q.oe;
    assign rd_issue    = !q.ld_n && q.rw_n;

endmodule

// File: rtl/ddrb2_rdtrack.sv
module ddrb2_rdtrack #(
    parameter int DW  = 18,
    parameter int RDC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_issue,
    input  logic [DW-1:0] mem_rd_rise,
    input  logic [DW-1:0] mem_rd_fall,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata0,
    output logic [DW-1:0] rsp_rdata1
);
    localparam int PW = (RDC < 1) ? 1 : RDC;

    typedef struct packed {
        logic [PW-1:0] pipe;
        logic          vld;
        logic [DW-1:0] r0;
        logic [DW-1:0] r1;
    } track_t;

    track_t q, d;

    always_comb begin
        d      = q;
        d.pipe = (q.pipe << 1) | PW'(rd_issue);
        d.vld  = q.pipe[PW-1];
        if (q.pipe[PW-1]) begin
            d.r0 = mem_rd_rise;
            d.r1 = mem_rd_fall;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid  = q.vld;
    assign rsp_rdata0 = q.r0;
    assign rsp_rdata1 = q.r1;

endmodule

// File: rtl/ddrb2_ctrl.sv
module ddrb2_ctrl #(
    parameter int       AW          = 19,
    parameter int       DW          = 18,
    parameter bit [1:0] RD_LAT_HALF = 2'd3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata0,
    input  logic [DW-1:0] req_wdata1,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata0,
    output logic [DW-1:0] rsp_rdata1,
    output logic          mem_ld_n,
    output logic          mem_rw_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wd_rise,
    output logic [DW-1:0] mem_wd_fall,
    output logic          mem_wd_oe,
    input  logic [DW-1:0] mem_rd_rise,
    input  logic [DW-1:0] mem_rd_fall
);
    localparam int RDC = ddrb2_pkg::rd_cycles(int'(RD_LAT_HALF));

    logic rd_issue;

    ddrb2_issue #(.AW(AW), .DW(DW)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata0  (req_wdata0),
        .req_wdata1  (req_wdata1),
        .req_ready   (req_ready),
        .mem_ld_n    (mem_ld_n),
        .mem_rw_n    (mem_rw_n),
        .mem_addr    (mem_addr),
        .mem_wd_rise (mem_wd_rise),
        .mem_wd_fall (mem_wd_fall),
        .mem_wd_oe   (mem_wd_oe),
        .rd_issue    (rd_issue)
    );

    ddrb2_rdtrack #(.DW(DW), .RDC(RDC)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_issue    (rd_issue),
        .mem_rd_rise (mem_rd_rise),
        .mem_rd_fall (mem_rd_fall),
        .rsp_valid   (rsp_valid),
        .rsp_rdata0  (rsp_rdata0),
        .rsp_rdata1  (rsp_rdata1)
    );

endmodule

// File: rtl/ddrb2_ctrl_chk.sv
module ddrb2_ctrl_chk #(
    parameter int RDC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_write,
    input logic req_ready,
    input logic rsp_valid,
    input logic mem_ld_n,
    input logic mem_rw_n,
    input logic mem_wd_oe
);
    // R2: a command cycle only follows an accepted request
    a_r2_cmd_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ld_n |-> $past(req_valid && req_ready));

    // R4: a write command is always followed by the drive cycle
    a_r4_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ld_n && !mem_rw_n) |=> mem_wd_oe);

    // R3 / R4: the bus is driven only right after a write command
    a_r3_oe_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wd_oe |-> $past(!mem_ld_n && !mem_rw_n));

    // R5: each response traces back to a read command at the fixed distance
    a_r5_rsp_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_ld_n && mem_rw_n, RDC + 1));

    // R7: no read is accepted directly after an accepted write
    a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> !(req_valid && req_ready && !req_write));

endmodule

bind ddrb2_ctrl ddrb2_ctrl_chk #(.RDC(RDC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ld_n  (mem_ld_n),
    .mem_rw_n  (mem_rw_n),
    .mem_wd_oe (mem_wd_oe)
);

// File: tb/ddrb2_ctrl_tb.sv
module ddrb2_ctrl_tb;
    localparam int AW   = 4;
    localparam int DW   = 16;
    localparam int NA   = 1 << AW;
    localparam int LATH = 3;
    localparam int RDCB = (LATH + 1) / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata0 = '0;
    logic [DW-1:0] req_wdata1 = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata0, rsp_rdata1;
    logic          mem_ld_n, mem_rw_n, mem_wd_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wd_rise, mem_wd_fall, mem_rd_rise, mem_rd_fall;

    always #10 clk = ~clk;

    ddrb2_ctrl #(.AW(AW), .DW(DW), .RD_LAT_HALF(2'(LATH))) u_dut (.*);

    // Behavioural two-word burst memory, pair = {A, A^1}
    logic [DW-1:0] mem [NA];
    logic          sv [RDCB];
    logic [DW-1:0] sr [RDCB];
    logic [DW-1:0] sf [RDCB];
    logic          wpend = 1'b0;
    logic [AW-1:0] waddr = '0;

    initial begin
        for (int i = 0; i < NA; i++) mem[i] = '0;
        for (int k = 0; k < RDCB; k++) begin sv[k] = 1'b0; sr[k] = '0; sf[k] = '0; end
    end

    always @(posedge clk) begin
        sv[0] <= !mem_ld_n && mem_rw_n;
        sr[0] <= mem[mem_addr];
        sf[0] <= mem[mem_addr ^ AW'(1)];
        for (int k = 1; k < RDCB; k++) begin
            sv[k] <= sv[k-1]; sr[k] <= sr[k-1]; sf[k] <= sf[k-1];
        end
        wpend <= !mem_ld_n && !mem_rw_n;
        waddr <= mem_addr;
        if (wpend && mem_wd_oe) begin
            mem[waddr]           <= mem_wd_rise;
            mem[waddr ^ AW'(1)]  <= mem_wd_fall;
        end
    end

    assign mem_rd_rise = sv[RDCB-1] ? sr[RDCB-1] : 16'hDEAD;
    assign mem_rd_fall = sv[RDCB-1] ? sf[RDCB-1] : 16'hBEEF;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [DW-1:0] shadow [NA];
    initial for (int i = 0; i < NA; i++) shadow[i] = '0;

    // expected responses
    logic [DW-1:0] eq0 [256];
    logic [DW-1:0] eq1 [256];
    int            eqc [256];
    int            wp = 0, rp = 0;

    // accepted-this-cycle record, set by the driver, consumed by the monitor
    logic          acc_v = 1'b0, acc_wr = 1'b0;
    logic [AW-1:0] acc_a = '0;
    logic [DW-1:0] acc_d0 = '0, acc_d1 = '0;
    logic          st1_v = 1'b0, st1_wr = 1'b0;
    logic          st2_wr = 1'b0;
    logic [DW-1:0] st2_d0 = '0, st2_d1 = '0;
    logic          monitor_on = 1'b0;

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (monitor_on) begin
            // R2 / R3 command pins
            if (acc_v) begin
                chk("R2 ld_n", mem_ld_n == 1'b0, int'(mem_ld_n), 0);
                chk("R2 rw_n", mem_rw_n == !acc_wr, int'(mem_rw_n), int'(!acc_wr));
                chk("R2 addr", mem_addr == acc_a, int'(mem_addr), int'(acc_a));
            end else begin
                chk("R3 nop ld_n", mem_ld_n == 1'b1, int'(mem_ld_n), 1);
            end
            // R4 write drive
            chk("R4 oe", mem_wd_oe == st2_wr, int'(mem_wd_oe), int'(st2_wr));
            if (st2_wr) begin
                chk("R4 rise", mem_wd_rise == st2_d0, int'(mem_wd_rise), int'(st2_d0));
                chk("R4 fall", mem_wd_fall == st2_d1, int'(mem_wd_fall), int'(st2_d1));
            end
            // R5 / R6 / R8 responses
            if (rsp_valid) begin
                if (rp == wp) begin
                    chk("R6 unexpected rsp", 1'b0, 1, 0);
                end else begin
                    chk("R5 latency", cyc == eqc[rp % 256] + RDCB + 2, cyc, eqc[rp % 256] + RDCB + 2);
                    chk("R8 word0", rsp_rdata0 == eq0[rp % 256], int'(rsp_rdata0), int'(eq0[rp % 256]));
                    chk("R8 word1", rsp_rdata1 == eq1[rp % 256], int'(rsp_rdata1), int'(eq1[rp % 256]));
                    rp++;
                end
            end
            st2_wr = acc_v && acc_wr;
            st2_d0 = acc_d0;
            st2_d1 = acc_d1;
            st1_v  = acc_v;
            st1_wr = acc_wr;
            acc_v  = 1'b0;
        end
    end

    task automatic issue(input logic wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] d0, input logic [DW-1:0] d1);
        logic done;
        logic exp_rdy;
        done = 1'b0;
        while (!done) begin
            @(negedge clk);
            req_valid = 1'b1; req_write = wr; req_addr = a;
            req_wdata0 = d0; req_wdata1 = d1;
            #1;
            exp_rdy = !(st1_v && st1_wr && !wr);
            chk("R7 ready", req_ready == exp_rdy, int'(req_ready), int'(exp_rdy));
            if (req_ready) begin
                done   = 1'b1;
                acc_v  = 1'b1; acc_wr = wr; acc_a = a; acc_d0 = d0; acc_d1 = d1;
                if (wr) begin
                    shadow[a]           = d0;
                    shadow[a ^ AW'(1)]  = d1;
                end else begin
                    eq0[wp % 256] = shadow[a];
                    eq1[wp % 256] = shadow[a ^ AW'(1)];
                    eqc[wp % 256] = cyc;
                    wp++;
                end
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 ld_n", mem_ld_n == 1'b1, int'(mem_ld_n), 1);
        chk("R1 rw_n", mem_rw_n == 1'b1, int'(mem_rw_n), 1);
        chk("R1 oe", mem_wd_oe == 1'b0, int'(mem_wd_oe), 0);
        chk("R1 rsp_valid", rsp_valid == 1'b0, int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle ld_n", mem_ld_n == 1'b1, int'(mem_ld_n), 1);
        chk("R1 idle oe", mem_wd_oe == 1'b0, int'(mem_wd_oe), 0);
        monitor_on = 1'b1;

        // R8 even starts: back-to-back writes, then read every address
        for (int a = 0; a < NA; a += 2)
            issue(1'b1, AW'(a), DW'(16'h1000 + a * 7), DW'(16'h2000 + a * 11));
        for (int a = 0; a < NA; a++) issue(1'b0, AW'(a), '0, '0);
        idle(6);

        // R8 odd starts overwrite the pairs in reversed order
        for (int a = 1; a < NA; a += 2)
            issue(1'b1, AW'(a), DW'(16'h3000 + a * 5), DW'(16'h4000 + a * 13));
        for (int a = NA - 1; a >= 0; a--) issue(1'b0, AW'(a), '0, '0);
        idle(6);

        // R6 / R7 mixed: write then read the same pair, read then write
        for (int a = 0; a < NA; a++) begin
            issue(1'b1, AW'(a), DW'(16'h5000 + a), DW'(16'h6000 + a * 3));
            issue(1'b0, AW'(a), '0, '0);
            issue(1'b0, AW'(a ^ 1), '0, '0);
            issue(1'b1, AW'(a ^ 3), DW'(16'h7000 + a), DW'(16'h8000 + a));
            if (a % 4 == 3) idle(1);
        end
        idle(RDCB + 6);

        // R6: every read answered exactly once
        chk("R6 all responses", rp == wp, rp, wp);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule